// File: doc/BRIEF.md
# Codec-Paced Audio Slot Transmitter

This block feeds one outbound sample stream of a serial audio codec link. A small FIFO is filled ahead of time by a DMA engine: the block raises a DMA request while the FIFO is short of samples, and each DMA write strobe stores one word. Samples leave the FIFO only when the codec asks for them. Once per frame the serializer gives a frame-boundary strobe, and at that strobe the block samples the codec's slot request. If the request is active, the block pops one sample, places it in the outbound slot and sets the slot's valid tag in the frame header.

Two enable bits control the stream. The slot enable gates link activity. The DMA enable gates the DMA request and acts independently of the slot enable. If the codec requests a sample while the FIFO is empty, the block sends an empty slot and sets a sticky underrun flag. Software clears that flag with a write-one pulse.

Top module: `slot_tx_stream`

## Requirements
- R1: After reset, `slot_valid_o`, `slot_data_o` and `underrun_o` are 0 and the FIFO is empty.
- R2: The slot request is active low. When `frame_strobe_i` is high on a clock edge while `slot_en_i`=1, `slot_req_ni`=0 and the FIFO is not empty, the oldest sample is popped. From that edge onward `slot_data_o` carries the sample left-justified and `slot_valid_o`=1. Both outputs hold until the next frame strobe.
- R3: At a frame strobe with `slot_req_ni`=1, the slot is sent with `slot_valid_o`=0 and `slot_data_o`=0, and the FIFO is not popped.
- R4: While `slot_en_i`=0, requests are ignored: a frame strobe yields `slot_valid_o`=0 and zero data, and `underrun_o` is unchanged.
- R5: The FIFO holds DEPTH (default 8) samples in first-in first-out order. A `dma_wr_i` strobe while the FIFO is full, or while `slot_en_i`=0, is dropped.
- R6: `dma_req_o` is 1 exactly when `dma_en_i`=1 and the FIFO holds fewer than DEPTH/2 samples.
- R7: A request (enabled, active) at a frame strobe while the FIFO is empty sets `underrun_o` on that edge. The slot is then sent with `slot_valid_o`=0 and zero data.
- R8: `underrun_o` stays set until an `underrun_clr_i` pulse clears it. If an underrun occurs in the same cycle as a clear, the flag stays set.
- R9: A clock edge with `slot_en_i`=0 empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_en_i | input | 1 | Stream link enable |
| dma_en_i | input | 1 | DMA request enable |
| frame_strobe_i | input | 1 | One-cycle frame-boundary strobe |
| slot_req_ni | input | 1 | Codec slot request, active low, decoded from the codec's input line |
| dma_wr_i | input | 1 | DMA write strobe |
| dma_data_i | input | SAMPLE_W | Sample written by DMA |
| dma_req_o | output | 1 | DMA request |
| slot_data_o | output | SLOT_W | Outbound slot data, sample left-justified |
| slot_valid_o | output | 1 | Slot-valid tag for the outbound slot |
| underrun_o | output | 1 | Sticky underrun error |
| underrun_clr_i | input | 1 | Write-one-to-clear pulse for underrun |

## Verification
The request path is driven with three kinds of frame sequence. The first mixes requesting and idle frames over a partly filled FIFO, which shows that only requested frames pop and that idle frames leave the FIFO intact. The second drains a FIFO that was overfilled past its depth, which exposes lost or reordered words and the exact slot where underrun begins. The third issues requests with the link disabled and immediately after a flush, which separates ignored requests from stale data left in the FIFO. A DMA fill run across the half-depth threshold, and a clear pulse that coincides with an underrun, cover the request level and the priority between set and clear.

// File: rtl/slot_tx_pkg.sv
package slot_tx_pkg;
  localparam int unsigned SAMPLE_W_DEF = 20;
  localparam int unsigned SLOT_W_DEF   = 20;
  localparam int unsigned DEPTH_DEF    = 8;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_UNDER = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned W     = 20,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             rd_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_wr   = wr_i && !full_o && !flush_i;
  assign do_rd   = rd_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= inc_ptr(wptr_q);
      if (do_rd) rptr_q <= inc_ptr(rptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_full_write_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i) |=> full_o && $stable(wptr_q));
  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic             dma_en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             dma_req_o
);
  assign dma_req_o = dma_en_i && (count_i < CNT_W'(HALF));
endmodule

// File: rtl/slot_req_ctrl.sv
module slot_req_ctrl
  import slot_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned SLOT_W   = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_strobe_i,
  input  logic                slot_en_i,
  input  logic                req_ni,
  input  logic                empty_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                clr_i,
  output logic                pop_o,
  output logic [SLOT_W-1:0]   slot_data_o,
  output logic                slot_valid_o,
  output logic                underrun_o
);
  slot_kind_e           kind;
  logic [SLOT_W-1:0]    justified;
  logic [SLOT_W-1:0]    data_q;
  logic                 valid_q, under_q;

  always_comb begin
    kind = SLOT_IDLE;
    if (frame_strobe_i && slot_en_i && !req_ni)
      kind = empty_i ? SLOT_UNDER : SLOT_DATA;
  end

  assign pop_o = frame_strobe_i && (kind == SLOT_DATA);

  generate
    if (SLOT_W > SAMPLE_W) begin : g_pad
      assign justified = {sample_i, {(SLOT_W - SAMPLE_W){1'b0}}};
    end else begin : g_fit
      assign justified = sample_i[SAMPLE_W-1 -: SLOT_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (frame_strobe_i) begin
        valid_q <= (kind == SLOT_DATA);
        data_q  <= (kind == SLOT_DATA) ? justified : '0;
      end
      // set beats clear
      if (frame_strobe_i && kind == SLOT_UNDER) under_q <= 1'b1;
      else if (clr_i)                           under_q <= 1'b0;
    end
  end

  assign slot_data_o  = data_q;
  assign slot_valid_o = valid_q;
  assign underrun_o   = under_q;

  p_valid_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot_valid_o) |-> $past(frame_strobe_i && slot_en_i && !req_ni && !empty_i));
  p_hold_between_frames_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_strobe_i |=> $stable(slot_data_o) && $stable(slot_valid_o));
  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_valid_o |-> slot_data_o == '0);
  p_disabled_no_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_strobe_i && !slot_en_i) |=> !slot_valid_o && $stable(underrun_o));
  p_underrun_on_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_strobe_i && slot_en_i && !req_ni && empty_i) |=> underrun_o && !slot_valid_o);
  p_underrun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !clr_i) |=> underrun_o);
endmodule

// File: rtl/slot_tx_stream.sv
module slot_tx_stream
  import slot_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned SLOT_W   = SLOT_W_DEF,
  parameter int unsigned DEPTH    = DEPTH_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                slot_en_i,
  input  logic                dma_en_i,
  input  logic                frame_strobe_i,
  input  logic                slot_req_ni,
  input  logic                dma_wr_i,
  input  logic [SAMPLE_W-1:0] dma_data_i,
  output logic                dma_req_o,
  output logic [SLOT_W-1:0]   slot_data_o,
  output logic                slot_valid_o,
  output logic                underrun_o,
  input  logic                underrun_clr_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [SAMPLE_W-1:0] head;
  logic [CNT_W-1:0]    fill;
  logic                empty, full, pop;

  sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!slot_en_i),
    .wr_i    (dma_wr_i),
    .wdata_i (dma_data_i),
    .rd_i    (pop),
    .rdata_o (head),
    .count_o (fill),
    .empty_o (empty),
    .full_o  (full)
  );

  dma_pacer #(.DEPTH(DEPTH)) u_pacer (
    .dma_en_i  (dma_en_i),
    .count_i   (fill),
    .dma_req_o (dma_req_o)
  );

  slot_req_ctrl #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frame_strobe_i (frame_strobe_i),
    .slot_en_i      (slot_en_i),
    .req_ni         (slot_req_ni),
    .empty_i        (empty),
    .sample_i       (head),
    .clr_i          (underrun_clr_i),
    .pop_o          (pop),
    .slot_data_o    (slot_data_o),
    .slot_valid_o   (slot_valid_o),
    .underrun_o     (underrun_o)
  );

  p_pop_not_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> !empty);
  p_full_no_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !dma_req_o);
endmodule

// File: tb/slot_tx_stream_test.sv
`timescale 1ns/1ps
module slot_tx_stream_test;
  localparam int SW = 20;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic slot_en = 0, dma_en = 0, strobe = 0, req_n = 1, dma_wr = 0, clr = 0;
  logic [SW-1:0] dma_data = '0;
  logic dma_req, slot_valid, underrun;
  logic [SW-1:0] slot_data;

  int checks = 0, fails = 0;
  bit done = 0;
  int model_q[$];
  bit model_und = 0;
  bit exp_v_q[$];
  int exp_d_q[$];
  string exp_tag_q[$];
  logic chk_pending = 0;

  always #4 clk = ~clk;

  slot_tx_stream uut (
    .clk_i(clk), .rst_ni(rst_n), .slot_en_i(slot_en), .dma_en_i(dma_en),
    .frame_strobe_i(strobe), .slot_req_ni(req_n), .dma_wr_i(dma_wr),
    .dma_data_i(dma_data), .dma_req_o(dma_req), .slot_data_o(slot_data),
    .slot_valid_o(slot_valid), .underrun_o(underrun), .underrun_clr_i(clr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) chk_pending <= strobe;

  // monitor: compare slot outputs after each frame edge
  always @(negedge clk) begin
    if (chk_pending) begin
      if (exp_v_q.size() == 0) check("scoreboard empty", 1, 0);
      else begin
        automatic string t = exp_tag_q.pop_front();
        check({t, " valid"}, int'(slot_valid), int'(exp_v_q.pop_front()));
        check({t, " data"}, int'(slot_data), exp_d_q.pop_front());
      end
    end
  end

  task automatic status(string tag);
    check({tag, " dma_req R6"}, int'(dma_req), int'(dma_en && model_q.size() < DEPTH/2));
    check({tag, " underrun R8"}, int'(underrun), int'(model_und));
  endtask

  task automatic push(int w);
    dma_wr = 1; dma_data = w[SW-1:0];
    @(negedge clk);
    dma_wr = 0;
    if (slot_en && model_q.size() < DEPTH) model_q.push_back(w);
  endtask

  task automatic frame(bit req, bit with_clr, string tag);
    strobe = 1; req_n = !req; clr = with_clr;
    if (slot_en && req) begin
      if (model_q.size() > 0) begin
        exp_v_q.push_back(1); exp_d_q.push_back(model_q.pop_front());
      end else begin
        exp_v_q.push_back(0); exp_d_q.push_back(0); model_und = 1;
      end
    end else begin
      exp_v_q.push_back(0); exp_d_q.push_back(0);
      if (with_clr) model_und = 0;
    end
    exp_tag_q.push_back(tag);
    @(negedge clk);
    strobe = 0; req_n = 1; clr = 0;
    @(negedge clk);
  endtask

  task automatic set_en(bit v);
    slot_en = v;
    @(negedge clk);
    if (!v) model_q.delete();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(slot_valid), 0);
    check("R1 data", int'(slot_data), 0);
    check("R1 underrun", int'(underrun), 0);
    rst_n = 1;
    @(negedge clk);
    slot_en = 1; dma_en = 1;
    @(negedge clk);
    status("R1 after reset");

    frame(1, 0, "R7 empty request");
    status("R7 sticky");
    clr = 1; @(negedge clk); clr = 0; model_und = 0;
    status("R8 cleared");

    for (int i = 0; i < 3; i++) push('h11110 + i);
    status("R6 below half");
    push('h11113);
    status("R6 at half");

    frame(1, 0, "R2 first");
    frame(0, 0, "R3 idle");
    status("R3 fifo untouched");
    frame(1, 0, "R2 second");
    frame(1, 0, "R2 third");
    frame(1, 0, "R2 fourth");
    frame(1, 0, "R7 drained");
    status("R7 after drain");

    for (int i = 0; i < 10; i++) push('hA0000 + i * 'h111);
    status("R5 full");
    for (int i = 0; i < 9; i++) frame(1, 0, "R5 drain order");
    frame(1, 1, "R8 set beats clear");
    status("R8 set wins");
    clr = 1; @(negedge clk); clr = 0; model_und = 0;

    for (int i = 0; i < 2; i++) push('h5A5A0 + i);
    set_en(0);
    push('hFFFFF);
    frame(1, 0, "R4 disabled request");
    status("R4 underrun unchanged");
    set_en(1);
    status("R9 flushed");
    frame(1, 0, "R9 request after flush");
    clr = 1; @(negedge clk); clr = 0; model_und = 0;

    push('h2468A);
    frame(1, 0, "R2 after reenable");
    dma_en = 0;
    @(negedge clk);
    status("R6 dma disabled");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule